// File: doc/BRIEF.md
# Prioritized Interrupt Cause Notification Unit

This unit sits between a set of already-detected interrupt requests and a processor core. Every clock it looks at all pending requests and keeps those whose programmed priority lies strictly above a global mask level. It then selects the one with the greatest priority, preferring the lower source number on a tie. The winner's 5-bit source number and an "interrupt present" flag are registered into a current-status register. A handler reads that register to learn which source needs service.

The same status drives six interrupt-pending lines toward the processor. The lowest line is the interrupt-present flag. The upper five lines carry the selected cause number. How the topmost line is used depends on a timer-disable strap, which is sampled from data bus bit 7 while reset is held and frozen once reset is released. With the strap at 0, the topmost line passes the core's internal timer interrupt and only cause bits [3:0] appear below it. With the strap at 1, all five cause bits appear and the timer input is ignored.

Top module: `irqn_cause_unit`

## Requirements
- R1: One clock after the inputs are presented, `cause_o` holds the number of the eligible pending source with the greatest priority and `flag_o` is 1.
- R2: When several eligible sources share the greatest priority, the lowest source number is reported.
- R3: A source whose 3-bit priority (field `prio_i[3*i +: 3]`) is 0 is never selected.
- R4: A source is eligible only if its priority is strictly greater than `mask_lvl_i`.
- R5: When no eligible source is pending, `flag_o` is 0, `cause_o` is 0 and `ip_o[4:1]` is 0.
- R6: `ip_o[0]` (the lowest pending line) always equals `flag_o`.
- R7: With the captured strap at 0, `ip_o[5]` follows `timer_irq_i` and `ip_o[4:1]` equals `cause_o[3:0]`.
- R8: With the captured strap at 1, `ip_o[5:1]` equals `cause_o[4:0]` and `timer_irq_i` has no effect.
- R9: The strap takes the value of `strap_i` at the last clock edge with `rst_n` low and keeps it while reset stays released, whatever `strap_i` does afterwards.
- R10: While `rst_n` is low, `flag_o` and `cause_o` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_i | input | 1 | Data bus bit 7, captured as timer-disable during reset |
| req_i | input | 32 | Pending request per source |
| prio_i | input | 96 | 3-bit priority per source, source i at bits [3i+2:3i] |
| mask_lvl_i | input | 3 | System mask level |
| timer_irq_i | input | 1 | Core internal timer interrupt |
| cause_o | output | 5 | Status: selected source number |
| flag_o | output | 1 | Status: interrupt present |
| ip_o | output | 6 | Processor pending lines, bit 0 is the lowest |

## Verification
Request sets are applied with one pending source, with distinct priorities spread over low, middle and top source numbers, and with equal priorities. These patterns separate the greatest-priority rule from fixed-index ordering and confirm that ties go to the lower number. Priority-zero sources and sources at or below the mask level are paired with one eligible source and are also tried alone. This shows both that they are ignored and that the idle status reads zero. The pending-line mapping is checked with cause numbers whose bit 4 differs from the timer input, under each strap value and after the strap input flips following reset.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

    localparam int CAUSE_W = 5;
    localparam int NUM_SRC = 1 << CAUSE_W;
    localparam int IP_W    = CAUSE_W + 1;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               flag;
        logic               tdis;
    } irqn_stat_t;

endpackage

// File: rtl/irqn_prio_select.sv
module irqn_prio_select #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    localparam int CW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]    req_i,
    input  logic [NSRC*PW-1:0] prio_i,
    input  logic [PW-1:0]      mask_i,
    output logic               hit_o,
    output logic [CW-1:0]      idx_o
);

    logic [NSRC-1:0] elig;
    logic [PW-1:0]   lvl [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign lvl[g]  = prio_i[g*PW +: PW];
        assign elig[g] = req_i[g] && (lvl[g] > mask_i);
    end

    logic [PW-1:0] best_lvl;

    always_comb begin
        hit_o    = 1'b0;
        idx_o    = '0;
        best_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!hit_o || lvl[i] > best_lvl)) begin
                hit_o    = 1'b1;
                idx_o    = CW'(i);
                best_lvl = lvl[i];
            end
        end
    end

endmodule

// File: rtl/irqn_ip_map.sv
module irqn_ip_map
    import irqn_pkg::*;
(
    input  logic               tdis_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               flag_i,
    input  logic               timer_i,
    output logic [IP_W-1:0]    ip_o
);

    always_comb begin
        ip_o[0]                  = flag_i;
        ip_o[CAUSE_W-1:1]        = cause_i[CAUSE_W-2:0];
        ip_o[CAUSE_W]            = tdis_i ? cause_i[CAUSE_W-1] : timer_i;
    end

endmodule

// File: rtl/irqn_cause_unit.sv
module irqn_cause_unit
    import irqn_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_i,
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         mask_lvl_i,
    input  logic                      timer_irq_i,
    output logic [CAUSE_W-1:0]        cause_o,
    output logic                      flag_o,
    output logic [IP_W-1:0]           ip_o
);

    irqn_stat_t st_d, st_q;
    logic               sel_hit;
    logic [CAUSE_W-1:0] sel_idx;
    logic               tdis_w;

    irqn_prio_select #(
        .NSRC (NUM_SRC),
        .PW   (PRIO_W)
    ) u_sel (
        .req_i  (req_i),
        .prio_i (prio_i),
        .mask_i (mask_lvl_i),
        .hit_o  (sel_hit),
        .idx_o  (sel_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flag  = sel_hit;
        st_d.cause = sel_hit ? sel_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cause <= '0;
            st_q.flag  <= 1'b0;
            st_q.tdis  <= strap_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdis_w  = st_q.tdis;
    assign cause_o = st_q.cause;
    assign flag_o  = st_q.flag;

    irqn_ip_map u_map (
        .tdis_i  (tdis_w),
        .cause_i (st_q.cause),
        .flag_i  (st_q.flag),
        .timer_i (timer_irq_i),
        .ip_o    (ip_o)
    );

endmodule

// File: rtl/irqn_cause_chk.sv
module irqn_cause_chk
    import irqn_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SRC-1:0]        req_i,
    input logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]         mask_lvl_i,
    input logic                      timer_irq_i,
    input logic [CAUSE_W-1:0]        cause_o,
    input logic                      flag_o,
    input logic [IP_W-1:0]           ip_o,
    input logic                      tdis
);

    logic [NUM_SRC-1:0]        req_p;
    logic [NUM_SRC*PRIO_W-1:0] prio_p;
    logic [PRIO_W-1:0]         mask_p;
    logic                      vld_p;

    always_ff @(posedge clk) begin
        req_p  <= req_i;
        prio_p <= prio_i;
        mask_p <= mask_lvl_i;
        vld_p  <= rst_n;
    end

    a_r1_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_p && flag_o) |-> req_p[cause_o]);

    a_r4_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_p && flag_o) |-> (prio_p[int'(cause_o)*PRIO_W +: PRIO_W] > mask_p));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |-> (cause_o == '0 && ip_o[CAUSE_W-1:1] == '0));

    a_r6_flag_line: assert property (@(posedge clk) disable iff (!rst_n)
        ip_o[0] == flag_o);

    a_r7_timer_line: assert property (@(posedge clk) disable iff (!rst_n)
        !tdis |-> (ip_o[CAUSE_W] == timer_irq_i && ip_o[CAUSE_W-1:1] == cause_o[CAUSE_W-2:0]));

    a_r8_full_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tdis |-> (ip_o[CAUSE_W:1] == cause_o));

    a_r9_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        vld_p |-> $stable(tdis));

endmodule

bind irqn_cause_unit irqn_cause_chk #(.PRIO_W(PRIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .prio_i      (prio_i),
    .mask_lvl_i  (mask_lvl_i),
    .timer_irq_i (timer_irq_i),
    .cause_o     (cause_o),
    .flag_o      (flag_o),
    .ip_o        (ip_o),
    .tdis        (tdis_w)
);

// File: tb/sim_irqn_cause_unit.sv
module sim_irqn_cause_unit;

    localparam int CLK_P = 10;
    localparam int NS    = 32;
    localparam int PW    = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           strap;
    logic [NS-1:0]  req;
    logic [NS*PW-1:0] prio;
    logic [PW-1:0]  mask;
    logic           timer;
    logic [4:0]     cause;
    logic           flag;
    logic [5:0]     ip;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    irqn_cause_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap),
        .req_i       (req),
        .prio_i      (prio),
        .mask_lvl_i  (mask),
        .timer_irq_i (timer),
        .cause_o     (cause),
        .flag_o      (flag),
        .ip_o        (ip)
    );

    task automatic chk(input string rq, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", rq, got, exp);
        end
    endtask

    task automatic clear_in();
        req   = '0;
        prio  = '0;
        mask  = '0;
        timer = 1'b0;
    endtask

    task automatic put(input int src, input int lvl);
        req[src] = 1'b1;
        prio[src*PW +: PW] = PW'(lvl);
    endtask

    // apply at negedge, one posedge registers, sample at the next negedge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        clear_in();
        put(4, 7);
        step();
        step();
        chk("R10 flag in reset", int'(flag), 0);
        chk("R10 cause in reset", int'(cause), 0);
        rst_n = 1'b1;
        clear_in();
        step();
    endtask

    task automatic t_single();
        clear_in(); put(9, 3); step();
        chk("R1 single cause", int'(cause), 9);
        chk("R1 single flag", int'(flag), 1);
        chk("R6/R7 single ip", int'(ip), 6'b010011);
    endtask

    task automatic t_priority();
        clear_in(); put(2, 2); put(20, 6); put(31, 5); step();
        chk("R1 greatest priority", int'(cause), 20);
        chk("R7 ip with cause 20 timer 0", int'(ip), 6'b001001);
        timer = 1'b1; step();
        chk("R7 timer on top line", int'(ip), 6'b101001);
    endtask

    task automatic t_tie();
        clear_in(); put(25, 4); put(7, 4); put(3, 4); step();
        chk("R2 tie to lowest", int'(cause), 3);
    endtask

    task automatic t_zero();
        clear_in(); put(5, 0); step();
        chk("R3 prio0 flag", int'(flag), 0);
        chk("R5 idle cause", int'(cause), 0);
        chk("R5 idle ip", int'(ip), 0);
        put(30, 1); step();
        chk("R3 prio0 skipped", int'(cause), 30);
    endtask

    task automatic t_mask();
        clear_in(); mask = 3'd3; put(1, 3); put(12, 4); step();
        chk("R4 above mask", int'(cause), 12);
        req[12] = 1'b0; step();
        chk("R4 at mask not eligible", int'(flag), 0);
        chk("R5 masked cause zero", int'(cause), 0);
        mask = 3'd2; step();
        chk("R4 mask lowered", int'(cause), 1);
    endtask

    task automatic t_timer_idle();
        clear_in(); timer = 1'b1; step();
        chk("R7 timer alone", int'(ip), 6'b100000);
    endtask

    task automatic t_strap0_hold();
        strap = 1'b1;
        clear_in(); put(16, 2); step();
        chk("R9 strap 0 held", int'(ip), 6'b000001);
    endtask

    task automatic t_strap1();
        strap = 1'b0;
        clear_in(); put(20, 1); timer = 1'b1; step();
        chk("R8 full cause", int'(ip), 6'b101001);
        clear_in(); put(17, 1); step();
        chk("R9 strap 1 held", int'(ip), 6'b100011);
        clear_in(); timer = 1'b1; step();
        chk("R8 timer ignored", int'(ip), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        strap = 1'b0;
        clear_in();
        do_reset(1'b0);
        t_single();
        t_priority();
        t_tie();
        t_zero();
        t_mask();
        t_timer_idle();
        t_strap0_hold();
        do_reset(1'b1);
        t_strap1();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule